// File: doc/BRIEF.md
# Power and Sleep Controller

This block is a register-programmed controller for a set of power domains, each holding a fixed number of modules. Software picks a target state for each domain and then starts the transition with a per-domain start bit. To power a domain on, the controller raises that domain's memory wake request and holds it until the wake acknowledge comes back. Software takes no part in the wake sequence. While a domain is in transition, its busy flag is set. Domain 0 is on from power-up and can never be turned off. The other domains start out off. Once a domain is on, it stays on.

Every module has an enable bit that selects one of two states. In the running state the module clock is on and the module reset is released. In the disabled state the clock is stopped and the reset is held. A module in a domain that is off is held disabled, whatever its enable bit says.

Each module also owns a local core reset. Software controls it through a control bit, and a watchdog can force it through a request input. The local core reset never touches the module clock or the module reset, so the core's local memories stay reachable while the core is held.

Top module: `pwr_sleep_ctrl`

Register map (word addresses on `reg_addr`; writes take effect at the clock edge where `reg_we` is high; reads are combinational):
- 0: start. A write of 1 to bit d starts domain d. A read returns the busy flags, one bit per domain.
- 1: read-only domain state, bit d = 1 when domain d is on. Writes are ignored.
- 2: target state, bit d = 1 requests on. Resets to 1 for domain 0 and to 0 for the others.
- 4+m: control of module m (m = 0 .. NUM_DOM*MODS_PER_DOM-1). Module m belongs to domain m / MODS_PER_DOM.
  - Writable bits: bit 0 is the enable (1 = running, 0 = disabled) and resets to 0. Bit 1 is the local reset control (0 = hold the core, 1 = release it) and resets to 1.
  - Readable status bits: bit 2 is the module clock enable, bit 3 is the module reset (active low), and bit 4 is the core reset (active low).

## Requirements
- R1: After reset, domain 0 reads as on and every other domain as off. All busy flags and wake requests are 0. Every module clock is off, every module reset is asserted (mod_rst_n = 0), and every core reset is released (core_rst_n = 1).
- R2: When a module becomes enabled in a domain that is on, its clock enable rises at the edge after the control write. Its module reset is released one edge after that, never before the clock.
- R3: Writing 0 to a module's enable bit turns its clock off and asserts its module reset at the edge after the write. The module reset is never released while the clock is off.
- R4: Writing 0 to a module's local reset bit drives core_rst_n low at the next edge, and writing 1 drives it high again. Neither write changes the module clock or the module reset.
- R5: While a module's watchdog request is high, its core_rst_n is driven low from the next edge on. The module clock and the module reset are not affected.
- R6: A write of 1 to start bit d sets busy d and wake request d at that same edge, provided target bit d is 1 and domain d is off and idle. Otherwise the write is ignored.
- R7: The wake request stays high until the wake acknowledge is sampled high. At that edge the domain becomes on, its busy flag clears and its wake request drops.
- R8: A domain that is on stays on under any write, including a target of 0 followed by a start. Domain 0 is never off.
- R9: A wake acknowledge received while a domain is off and idle does not change that domain's state.
- R10: A module in a domain that is off keeps its clock off and its reset asserted, even when its enable bit is 1. Once the domain turns on, such a module follows the R2 sequence.
- R11: The target and module control registers read back what was written, and a module register's status bits show its clock, module reset and core reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| wake_ack | input | NUM_DOM | Per-domain memory wake acknowledge |
| wdog_lrst | input | NUM_DOM*MODS_PER_DOM | Per-module watchdog local reset request |
| wake_req | output | NUM_DOM | Per-domain memory wake request |
| mod_clk_en | output | NUM_DOM*MODS_PER_DOM | Module clock enables |
| mod_rst_n | output | NUM_DOM*MODS_PER_DOM | Module resets, active low |
| core_rst_n | output | NUM_DOM*MODS_PER_DOM | Local core resets, active low |

## Verification
The bench checks the edge-by-edge ordering of clock and reset when a module is enabled, both directly after a write and after its domain wakes. A design that released reset together with the clock, or ahead of it, would fail this check. It also tries to turn on domains that are already on, issues a second start while a domain is busy, and sends a wake acknowledge when no transition is running. A controller that powered a domain down, restarted a transition, or marked a domain on without a wake would show the wrong domain state or busy readback. Finally, the bench holds a core in local reset and under a watchdog request and checks that the module clock and module reset do not move. Coupling local reset to module reset would break this check.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    DS_OFF  = 2'd0,
    DS_WAKE = 2'd1,
    DS_ON   = 2'd2
  } dom_st_e;

  localparam int unsigned A_START  = 0;
  localparam int unsigned A_STATE  = 1;
  localparam int unsigned A_TARGET = 2;
  localparam int unsigned A_MOD0   = 4;

  // domain that owns module m
  function automatic int unsigned dom_index(int unsigned m, int unsigned per);
    return m / per;
  endfunction

  // layout of a module control register on read
  function automatic logic [4:0] mod_status(logic en, logic lrst, logic clk_on,
                                            logic mrst_n, logic crst_n);
    return {crst_n, mrst_n, clk_on, lrst, en};
  endfunction

endpackage

// File: rtl/psc_regs.sv
module psc_regs #(
  parameter int unsigned NUM_DOM = 3,
  parameter int unsigned NUM_MOD = 6,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_DOM-1:0] busy,
  input  logic [NUM_DOM-1:0] dom_on,
  input  logic [NUM_MOD-1:0] clk_en,
  input  logic [NUM_MOD-1:0] mrst_n,
  input  logic [NUM_MOD-1:0] crst_n,
  output logic [NUM_DOM-1:0] go,
  output logic [NUM_DOM-1:0] target,
  output logic [NUM_MOD-1:0] mod_en,
  output logic [NUM_MOD-1:0] lrst_ctl
);
  import psc_pkg::*;

  localparam logic [NUM_DOM-1:0] TGT_RST = NUM_DOM'(1);

  logic hit_start, hit_state, hit_target;
  logic unused_wdata_bits;

  assign hit_start  = (addr == ADDR_W'(A_START));
  assign hit_state  = (addr == ADDR_W'(A_STATE));
  assign hit_target = (addr == ADDR_W'(A_TARGET));
  assign unused_wdata_bits = ^wdata;

  // start pulses are not stored: the domain FSM samples them on this edge
  assign go = (we && hit_start) ? wdata[NUM_DOM-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target   <= TGT_RST;
      mod_en   <= '0;
      lrst_ctl <= '1;
    end else if (we) begin
      if (hit_target) target <= wdata[NUM_DOM-1:0];
      for (int m = 0; m < int'(NUM_MOD); m++) begin
        if (addr == ADDR_W'(A_MOD0 + m)) begin
          mod_en[m]   <= wdata[0];
          lrst_ctl[m] <= wdata[1];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_start)  rdata[NUM_DOM-1:0] = busy;
    if (hit_state)  rdata[NUM_DOM-1:0] = dom_on;
    if (hit_target) rdata[NUM_DOM-1:0] = target;
    for (int m = 0; m < int'(NUM_MOD); m++) begin
      if (addr == ADDR_W'(A_MOD0 + m))
        rdata[4:0] = mod_status(mod_en[m], lrst_ctl[m], clk_en[m], mrst_n[m], crst_n[m]);
    end
  end

endmodule

// File: rtl/psc_dom.sv
module psc_dom #(
  parameter bit RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic target_on,
  input  logic wake_ack,
  output logic dom_on,
  output logic busy,
  output logic wake_req
);
  import psc_pkg::*;

  localparam dom_st_e ST_RST = RESET_ON ? DS_ON : DS_OFF;

  dom_st_e st;
  logic    start_ev;
  logic    done_ev;

  assign start_ev = (st == DS_OFF) && go && target_on;
  assign done_ev  = (st == DS_WAKE) && wake_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RST;
    end else begin
      case (st)
        DS_OFF:  if (start_ev) st <= DS_WAKE;
        DS_WAKE: if (done_ev)  st <= DS_ON;
        DS_ON:   st <= DS_ON;
        default: st <= ST_RST;
      endcase
    end
  end

  assign busy     = (st == DS_WAKE);
  assign wake_req = (st == DS_WAKE);
  assign dom_on   = (st == DS_ON);

  p_never_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dom_on |=> dom_on);
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && target_on && !dom_on && !busy) |=> (busy && wake_req));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack) |=> wake_req);
  p_done_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dom_on);
  p_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !dom_on && !go) |=> !dom_on);

endmodule

// File: rtl/psc_mod.sv
module psc_mod (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dom_on,
  input  logic lrst_ctl,
  input  logic wdog_req,
  output logic clk_en,
  output logic mrst_n,
  output logic crst_n
);
  logic run_ok;
  logic core_hold;

  assign run_ok    = en_req && dom_on;
  assign core_hold = !lrst_ctl || wdog_req;

  // reset release trails the clock by one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
      mrst_n <= 1'b0;
      crst_n <= 1'b1;
    end else begin
      clk_en <= run_ok;
      mrst_n <= run_ok && clk_en;
      crst_n <= !core_hold;
    end
  end

  p_clk_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrst_n) |-> $past(clk_en));
  p_rst_needs_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_n |-> clk_en);
  p_off_domain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_on |=> (!clk_en && !mrst_n));
  p_wdog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_req |=> !crst_n);
  p_lrst_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && dom_on && mrst_n) |=> mrst_n);

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl #(
  parameter int unsigned NUM_DOM      = 3,
  parameter int unsigned MODS_PER_DOM = 2,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DATA_W       = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [ADDR_W-1:0]                reg_addr,
  input  logic [DATA_W-1:0]                reg_wdata,
  output logic [DATA_W-1:0]                reg_rdata,
  input  logic [NUM_DOM-1:0]               wake_ack,
  input  logic [NUM_DOM*MODS_PER_DOM-1:0]  wdog_lrst,
  output logic [NUM_DOM-1:0]               wake_req,
  output logic [NUM_DOM*MODS_PER_DOM-1:0]  mod_clk_en,
  output logic [NUM_DOM*MODS_PER_DOM-1:0]  mod_rst_n,
  output logic [NUM_DOM*MODS_PER_DOM-1:0]  core_rst_n
);
  import psc_pkg::*;

  localparam int unsigned NUM_MOD = NUM_DOM * MODS_PER_DOM;

  logic [NUM_DOM-1:0] go, target, dom_on, busy;
  logic [NUM_MOD-1:0] mod_en, lrst_ctl;

  psc_regs #(
    .NUM_DOM(NUM_DOM), .NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .dom_on(dom_on), .clk_en(mod_clk_en),
    .mrst_n(mod_rst_n), .crst_n(core_rst_n), .go(go), .target(target),
    .mod_en(mod_en), .lrst_ctl(lrst_ctl)
  );

  // domain 0 comes out of reset already on
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    psc_dom #(.RESET_ON(d == 0)) u_dom (
      .clk(clk), .rst_n(rst_n), .go(go[d]), .target_on(target[d]),
      .wake_ack(wake_ack[d]), .dom_on(dom_on[d]), .busy(busy[d]),
      .wake_req(wake_req[d])
    );
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    psc_mod u_mod (
      .clk(clk), .rst_n(rst_n), .en_req(mod_en[m]),
      .dom_on(dom_on[dom_index(m, MODS_PER_DOM)]),
      .lrst_ctl(lrst_ctl[m]), .wdog_req(wdog_lrst[m]),
      .clk_en(mod_clk_en[m]), .mrst_n(mod_rst_n[m]), .crst_n(core_rst_n[m])
    );
  end

endmodule

// File: tb/pwr_sleep_ctrl_bench.sv
module pwr_sleep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [ND-1:0] wake_ack = '0;
  logic [NM-1:0] wdog_lrst = '0;
  logic [ND-1:0] wake_req;
  logic [NM-1:0] mod_clk_en, mod_rst_n, core_rst_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl u_pwr_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_ack(wake_ack),
    .wdog_lrst(wdog_lrst), .wake_req(wake_req), .mod_clk_en(mod_clk_en),
    .mod_rst_n(mod_rst_n), .core_rst_n(core_rst_n)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  rd_addr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // module read: {core_rst_n, mod_rst_n, clk_en, lrst, en}
  localparam vec_t VECS [9] = '{
    '{4'd4, 32'h3, 4'd4, 32'h1F, 8'd2},  // R2 m0 running
    '{4'd4, 32'h1, 4'd4, 32'h0D, 8'd4},  // R4 core held, module untouched
    '{4'd4, 32'h2, 4'd4, 32'h12, 8'd3},  // R3 m0 disabled
    '{4'd5, 32'h3, 4'd5, 32'h1F, 8'd2},  // R2 m1 running
    '{4'd6, 32'h3, 4'd6, 32'h13, 8'd10}, // R10 m2 in off domain
    '{4'd1, 32'h0, 4'd1, 32'h01, 8'd8},  // R8 state register not writable
    '{4'd2, 32'h0, 4'd2, 32'h00, 8'd11}, // R11 target readback
    '{4'd0, 32'h1, 4'd0, 32'h00, 8'd8},  // R8 start on always-on domain
    '{4'd0, 32'h2, 4'd0, 32'h00, 8'd6}   // R6 start with target off
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 wake_req", 32'(wake_req), 32'h0);
    chk("R1 clk_en", 32'(mod_clk_en), 32'h0);
    chk("R1 mod_rst_n", 32'(mod_rst_n), 32'h0);
    chk("R1 core_rst_n", 32'(core_rst_n), 32'h3F);
    rd(4'd1, r); chk("R1 state", r, 32'h1);
    rd(4'd0, r); chk("R1 busy", r, 32'h0);
    rd(4'd4, r); chk("R11 module reset value", r, 32'h12);

    for (int i = 0; i < 9; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      repeat (3) @(negedge clk);
      rd(VECS[i].rd_addr, r);
      checks++;
      if (r !== VECS[i].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].req, i, r, VECS[i].exp);
      end
    end

    // R2 ordering on m0
    wr(4'd4, 32'h3);
    chk("R2 clk still off", 32'(mod_clk_en[0]), 32'h0);
    @(negedge clk);
    chk("R2 clk on", 32'(mod_clk_en[0]), 32'h1);
    chk("R2 reset still held", 32'(mod_rst_n[0]), 32'h0);
    @(negedge clk);
    chk("R2 reset released", 32'(mod_rst_n[0]), 32'h1);

    // R5 watchdog on m1
    wdog_lrst[1] = 1'b1;
    @(negedge clk);
    chk("R5 core held", 32'(core_rst_n[1]), 32'h0);
    chk("R5 module reset", 32'(mod_rst_n[1]), 32'h1);
    chk("R5 module clock", 32'(mod_clk_en[1]), 32'h1);
    wdog_lrst[1] = 1'b0;
    @(negedge clk);
    chk("R5 core released", 32'(core_rst_n[1]), 32'h1);

    // R9 stray acknowledge
    wake_ack[1] = 1'b1;
    @(negedge clk);
    wake_ack[1] = 1'b0;
    rd(4'd1, r); chk("R9 state after stray ack", r, 32'h1);

    // R6/R7 wake domain 1
    wr(4'd2, 32'h6);
    wr(4'd0, 32'h2);
    rd(4'd0, r); chk("R6 busy set", r, 32'h2);
    chk("R6 wake_req", 32'(wake_req), 32'h2);
    repeat (3) @(negedge clk);
    chk("R7 request held", 32'(wake_req), 32'h2);
    chk("R10 m2 still off", 32'(mod_clk_en[2]), 32'h0);
    wake_ack[1] = 1'b1;
    @(negedge clk);
    wake_ack[1] = 1'b0;
    rd(4'd1, r); chk("R7 domain on", r, 32'h3);
    rd(4'd0, r); chk("R7 busy cleared", r, 32'h0);
    chk("R7 request dropped", 32'(wake_req), 32'h0);
    @(negedge clk);
    chk("R10 m2 clk on", 32'(mod_clk_en[2]), 32'h1);
    chk("R10 m2 reset held", 32'(mod_rst_n[2]), 32'h0);
    @(negedge clk);
    chk("R10 m2 reset released", 32'(mod_rst_n[2]), 32'h1);

    // R6 second start while busy on domain 2
    wr(4'd0, 32'h4);
    wr(4'd0, 32'h4);
    rd(4'd0, r); chk("R6 busy during repeat start", r, 32'h4);
    wake_ack[2] = 1'b1;
    @(negedge clk);
    wake_ack[2] = 1'b0;
    rd(4'd1, r); chk("R7 domain 2 on", r, 32'h7);

    // R8 turn-off attempt
    wr(4'd2, 32'h0);
    wr(4'd0, 32'h7);
    @(negedge clk);
    rd(4'd1, r); chk("R8 domains stay on", r, 32'h7);
    rd(4'd0, r); chk("R8 no busy", r, 32'h0);
    chk("R8 m2 still running", 32'(mod_clk_en[2]), 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule